// File: doc/BRIEF.md
# PCI Bus Transaction Monitor

This block passively observes a 32-bit PCI bus and turns every clock of bus activity into one decoded trace record. All bus lines except the clock are first registered on the rising PCI clock edge, and only those registered copies are decoded. A small phase tracker follows each transaction through its address and data phases. It splits the shared address/data lines into a held address and a per-phase data word, and splits the shared command/byte-enable lines into a held command and per-phase byte enables.

Each record carries phase flags (idle, address phase, data phase, completed transfer), a parity-valid flag, a parity-error flag, the command with its class and a reserved-code flag, and two protocol error flags. The first error flag marks a transfer that no target claimed. The second marks a special cycle that a target claimed. Records are meant for a trace buffer or a trigger unit. The record stream has a valid strobe and no ready input: the monitor cannot stall the bus it watches, so the consumer must take one record on every clock in which `mon_valid` is high.

Top module: `pcimon_top`

## Requirements
- R1: Bus values present at rising edge k appear as a record on the outputs after edge k+1. `mon_valid` rises with the first record after reset and stays high.
- R2: `mon_idle` is 1 exactly when the sampled FRAME# and IRDY# are both high. An idle sample also ends any transaction in progress.
- R3: When no transaction is in progress, a sample with FRAME# low is an address phase. `mon_addr_ph` is 1, `mon_cmd` loads the C/BE# nibble and `mon_addr` loads AD. `mon_addr` changes on no other record.
- R4: When the command is 1101 (dual address), the next sample is also an address phase. `mon_cmd` loads that second nibble and `mon_addr` is not reloaded.
- R5: Samples after the address phase(s) are data phases (`mon_data_ph`=1), and `mon_data`/`mon_be_n` load AD and C/BE#. `mon_xfer` is 1 in a data phase where IRDY# and TRDY# are both low.
- R6: A transaction ends after a data phase with FRAME# high, IRDY# low and either TRDY# or STOP# low. The next FRAME#-low sample is then a new address phase, even when no idle sample comes between.
- R7: `mon_class` is derived from `mon_cmd[3:1]`: 001 gives 01 (I/O), 011 gives 10 (memory), 101 gives 11 (configuration), and anything else gives 00. `mon_cmd_rsvd` is 1 for commands 0100, 0101, 1000 and 1001.
- R8: `mon_par_valid` is 1 on exactly the records that follow an address-phase record or a transfer record.
- R9: `mon_par_err` is 1 when `mon_par_valid` is 1 and the sampled PAR differs from the XOR of the previous sample's AD and C/BE# (even parity).
- R10: `mon_err_nodev` is 1 in a transfer data phase of a non-special transaction (command not 0001) while DEVSEL# is high.
- R11: `mon_err_spdev` is 1 in a data phase of a special cycle (command 0001) while DEVSEL# is low.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Multiplexed address/data lines |
| bus_cbe_n | input | 4 | Multiplexed command/byte-enable lines |
| bus_par | input | 1 | Parity line |
| bus_frame_n | input | 1 | FRAME#, active low |
| bus_irdy_n | input | 1 | IRDY#, active low |
| bus_trdy_n | input | 1 | TRDY#, active low |
| bus_devsel_n | input | 1 | DEVSEL#, active low |
| bus_stop_n | input | 1 | STOP#, active low |
| mon_valid | output | 1 | Record strobe, one record per clock |
| mon_idle | output | 1 | Bus idle in this record |
| mon_addr_ph | output | 1 | Address phase |
| mon_data_ph | output | 1 | Data phase |
| mon_xfer | output | 1 | Data phase that moved data |
| mon_par_valid | output | 1 | PAR in this record covers the previous one |
| mon_par_err | output | 1 | Parity mismatch |
| mon_cmd | output | 4 | Held command of the current transaction |
| mon_class | output | 2 | Command class |
| mon_cmd_rsvd | output | 1 | Held command is a reserved code |
| mon_addr | output | 32 | Held address |
| mon_data | output | 32 | Data of the latest data phase |
| mon_be_n | output | 4 | Byte enables of the latest data phase |
| mon_err_nodev | output | 1 | Transfer with no target selected |
| mon_err_spdev | output | 1 | Target selected in a special cycle |

## Verification
The assertions assume the bus follows the transaction shape: a dual address command is never followed by another dual address command, and no idle sample falls between the two address clocks. Under that shape the flags stay mutually exclusive, parity validity follows address and transfer records, and the held address only moves on address records. The scripted stimulus drives only well-formed framing: every transaction starts from idle or right after a completed termination and ends by a termination or by the master releasing the bus. Faults are injected only on DEVSEL# and PAR, so every error flag the bench sees is one of the intended ones.

// File: rtl/pcimon_pkg.sv
`timescale 1ns/1ps
package pcimon_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_IO    = 2'b01,
    CLS_MEM   = 2'b10,
    CLS_CFG   = 2'b11
  } cmd_class_e;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'b00,
    TRK_DAC2 = 2'b01,
    TRK_DATA = 2'b10
  } trk_state_e;

  localparam int          CMD_W         = 4;
  localparam logic [3:0]  CMD_SPECIAL   = 4'b0001;
  localparam logic [3:0]  CMD_DUAL_ADDR = 4'b1101;

  function automatic cmd_class_e class_of(input logic [3:0] cmd);
    unique case (cmd[3:1])
      3'b001:  return CLS_IO;
      3'b011:  return CLS_MEM;
      3'b101:  return CLS_CFG;
      default: return CLS_OTHER;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [3:0] cmd);
    return (cmd == 4'b0100) || (cmd == 4'b0101) ||
           (cmd == 4'b1000) || (cmd == 4'b1001);
  endfunction

endpackage

// File: rtl/pcimon_sampler.sv
`timescale 1ns/1ps
module pcimon_sampler #(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] bus_ad,
  input  logic [BE_W-1:0] bus_cbe_n,
  input  logic            bus_par,
  input  logic            bus_frame_n,
  input  logic            bus_irdy_n,
  input  logic            bus_trdy_n,
  input  logic            bus_devsel_n,
  input  logic            bus_stop_n,
  output logic            s_valid,
  output logic [AD_W-1:0] s_ad,
  output logic [BE_W-1:0] s_cbe_n,
  output logic            s_par,
  output logic            s_frame_n,
  output logic            s_irdy_n,
  output logic            s_trdy_n,
  output logic            s_devsel_n,
  output logic            s_stop_n
);

  // Every bus line is captured on the clock edge before any decode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid    <= 1'b0;
      s_ad       <= '0;
      s_cbe_n    <= '0;
      s_par      <= 1'b0;
      s_frame_n  <= 1'b1;
      s_irdy_n   <= 1'b1;
      s_trdy_n   <= 1'b1;
      s_devsel_n <= 1'b1;
      s_stop_n   <= 1'b1;
    end else begin
      s_valid    <= 1'b1;
      s_ad       <= bus_ad;
      s_cbe_n    <= bus_cbe_n;
      s_par      <= bus_par;
      s_frame_n  <= bus_frame_n;
      s_irdy_n   <= bus_irdy_n;
      s_trdy_n   <= bus_trdy_n;
      s_devsel_n <= bus_devsel_n;
      s_stop_n   <= bus_stop_n;
    end
  end

endmodule

// File: rtl/pcimon_tracker.sv
`timescale 1ns/1ps
module pcimon_tracker
  import pcimon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  input  logic [3:0] s_cmd,
  input  logic       s_frame_n,
  input  logic       s_irdy_n,
  input  logic       s_trdy_n,
  input  logic       s_devsel_n,
  input  logic       s_stop_n,
  output logic       ph_idle,
  output logic       ph_addr,
  output logic       ph_addr_first,
  output logic       ph_data,
  output logic       ph_xfer,
  output logic       ph_err_nodev,
  output logic       ph_err_spdev
);

  trk_state_e st_q, st_d;
  logic       spec_q, spec_d;
  logic       bus_idle;
  logic       done_c;

  assign bus_idle = s_frame_n & s_irdy_n;
  // Final data phase: master released FRAME# and the phase completed or was stopped.
  assign done_c   = s_frame_n & ~s_irdy_n & (~s_trdy_n | ~s_stop_n);

  always_comb begin
    st_d          = st_q;
    spec_d        = spec_q;
    ph_idle       = 1'b0;
    ph_addr       = 1'b0;
    ph_addr_first = 1'b0;
    ph_data       = 1'b0;
    ph_xfer       = 1'b0;
    ph_err_nodev  = 1'b0;
    ph_err_spdev  = 1'b0;
    if (s_valid) begin
      ph_idle = bus_idle;
      if (bus_idle) begin
        st_d = TRK_IDLE;
      end else begin
        unique case (st_q)
          TRK_IDLE: begin
            if (!s_frame_n) begin
              ph_addr       = 1'b1;
              ph_addr_first = 1'b1;
              spec_d        = (s_cmd == CMD_SPECIAL);
              st_d          = (s_cmd == CMD_DUAL_ADDR) ? TRK_DAC2 : TRK_DATA;
            end
          end
          TRK_DAC2: begin
            ph_addr = 1'b1;
            spec_d  = (s_cmd == CMD_SPECIAL);
            st_d    = TRK_DATA;
          end
          TRK_DATA: begin
            ph_data      = 1'b1;
            ph_xfer      = ~s_irdy_n & ~s_trdy_n;
            ph_err_nodev = ~spec_q & ~s_irdy_n & ~s_trdy_n & s_devsel_n;
            ph_err_spdev = spec_q & ~s_devsel_n;
            if (done_c) st_d = TRK_IDLE;
          end
          default: st_d = TRK_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_IDLE;
      spec_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      spec_q <= spec_d;
    end
  end

endmodule

// File: rtl/pcimon_parity.sv
`timescale 1ns/1ps
module pcimon_parity #(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8,
  localparam int PW   = AD_W + BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  input  logic [AD_W-1:0] s_ad,
  input  logic [BE_W-1:0] s_cbe_n,
  input  logic            s_par,
  input  logic            carry_next,
  output logic            par_valid,
  output logic            par_err
);

  logic [PW-1:0] covered;
  logic          calc_q;
  logic          due_q;

  assign covered = {s_ad, s_cbe_n};

  // Only one bit of the prior sample is kept: its even-parity value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q <= 1'b0;
      due_q  <= 1'b0;
    end else if (s_valid) begin
      calc_q <= ^covered;
      due_q  <= carry_next;
    end
  end

  assign par_valid = s_valid & due_q;
  assign par_err   = s_valid & due_q & (s_par != calc_q);

endmodule

// File: rtl/pcimon_top.sv
`timescale 1ns/1ps
module pcimon_top
  import pcimon_pkg::*;
#(
  parameter int AD_W = 32,
  localparam int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] bus_ad,
  input  logic [BE_W-1:0] bus_cbe_n,
  input  logic            bus_par,
  input  logic            bus_frame_n,
  input  logic            bus_irdy_n,
  input  logic            bus_trdy_n,
  input  logic            bus_devsel_n,
  input  logic            bus_stop_n,
  output logic            mon_valid,
  output logic            mon_idle,
  output logic            mon_addr_ph,
  output logic            mon_data_ph,
  output logic            mon_xfer,
  output logic            mon_par_valid,
  output logic            mon_par_err,
  output logic [3:0]      mon_cmd,
  output logic [1:0]      mon_class,
  output logic            mon_cmd_rsvd,
  output logic [AD_W-1:0] mon_addr,
  output logic [AD_W-1:0] mon_data,
  output logic [BE_W-1:0] mon_be_n,
  output logic            mon_err_nodev,
  output logic            mon_err_spdev
);

  logic            s_valid;
  logic [AD_W-1:0] s_ad;
  logic [BE_W-1:0] s_cbe_n;
  logic            s_par, s_frame_n, s_irdy_n, s_trdy_n, s_devsel_n, s_stop_n;

  logic ph_idle, ph_addr, ph_addr_first, ph_data, ph_xfer;
  logic ph_err_nodev, ph_err_spdev;
  logic par_valid_c, par_err_c;
  logic [3:0] cmd_next;

  pcimon_sampler #(.AD_W(AD_W)) u_sampler (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ad       (bus_ad),
    .bus_cbe_n    (bus_cbe_n),
    .bus_par      (bus_par),
    .bus_frame_n  (bus_frame_n),
    .bus_irdy_n   (bus_irdy_n),
    .bus_trdy_n   (bus_trdy_n),
    .bus_devsel_n (bus_devsel_n),
    .bus_stop_n   (bus_stop_n),
    .s_valid      (s_valid),
    .s_ad         (s_ad),
    .s_cbe_n      (s_cbe_n),
    .s_par        (s_par),
    .s_frame_n    (s_frame_n),
    .s_irdy_n     (s_irdy_n),
    .s_trdy_n     (s_trdy_n),
    .s_devsel_n   (s_devsel_n),
    .s_stop_n     (s_stop_n)
  );

  pcimon_tracker u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_valid       (s_valid),
    .s_cmd         (s_cbe_n[3:0]),
    .s_frame_n     (s_frame_n),
    .s_irdy_n      (s_irdy_n),
    .s_trdy_n      (s_trdy_n),
    .s_devsel_n    (s_devsel_n),
    .s_stop_n      (s_stop_n),
    .ph_idle       (ph_idle),
    .ph_addr       (ph_addr),
    .ph_addr_first (ph_addr_first),
    .ph_data       (ph_data),
    .ph_xfer       (ph_xfer),
    .ph_err_nodev  (ph_err_nodev),
    .ph_err_spdev  (ph_err_spdev)
  );

  pcimon_parity #(.AD_W(AD_W)) u_parity (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_ad       (s_ad),
    .s_cbe_n    (s_cbe_n),
    .s_par      (s_par),
    .carry_next (ph_addr | ph_xfer),
    .par_valid  (par_valid_c),
    .par_err    (par_err_c)
  );

  assign cmd_next = ph_addr ? s_cbe_n[3:0] : mon_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_valid     <= 1'b0;
      mon_idle      <= 1'b0;
      mon_addr_ph   <= 1'b0;
      mon_data_ph   <= 1'b0;
      mon_xfer      <= 1'b0;
      mon_par_valid <= 1'b0;
      mon_par_err   <= 1'b0;
      mon_cmd       <= '0;
      mon_class     <= CLS_OTHER;
      mon_cmd_rsvd  <= 1'b0;
      mon_addr      <= '0;
      mon_data      <= '0;
      mon_be_n      <= '0;
      mon_err_nodev <= 1'b0;
      mon_err_spdev <= 1'b0;
    end else begin
      mon_valid     <= s_valid;
      mon_idle      <= ph_idle;
      mon_addr_ph   <= ph_addr;
      mon_data_ph   <= ph_data;
      mon_xfer      <= ph_xfer;
      mon_par_valid <= par_valid_c;
      mon_par_err   <= par_err_c;
      mon_cmd       <= cmd_next;
      mon_class     <= class_of(cmd_next);
      mon_cmd_rsvd  <= is_reserved(cmd_next);
      mon_err_nodev <= ph_err_nodev;
      mon_err_spdev <= ph_err_spdev;
      if (ph_addr_first) mon_addr <= s_ad;
      if (ph_data) begin
        mon_data <= s_ad;
        mon_be_n <= s_cbe_n;
      end
    end
  end

endmodule

// File: rtl/pcimon_checker.sv
`timescale 1ns/1ps
module pcimon_checker #(
  parameter int AD_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mon_valid,
  input logic            mon_idle,
  input logic            mon_addr_ph,
  input logic            mon_data_ph,
  input logic            mon_xfer,
  input logic            mon_par_valid,
  input logic            mon_par_err,
  input logic [3:0]      mon_cmd,
  input logic [AD_W-1:0] mon_addr,
  input logic            mon_err_nodev,
  input logic            mon_err_spdev
);

  p_valid_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mon_valid |=> mon_valid);

  p_phase_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mon_idle, mon_addr_ph, mon_data_ph}));

  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_addr_ph |-> $stable(mon_addr));

  p_dual_addr_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_addr_ph && mon_cmd == 4'b1101) |=> mon_addr_ph);

  p_xfer_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_xfer |-> mon_data_ph);

  p_par_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_addr_ph || mon_xfer) |=> mon_par_valid);

  p_par_only_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_par_valid |-> $past(mon_addr_ph || mon_xfer));

  p_parerr_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_par_err |-> mon_par_valid);

  p_nodev_on_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_err_nodev |-> (mon_xfer && !mon_err_spdev));

  p_spdev_in_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mon_err_spdev |-> mon_data_ph);

endmodule

bind pcimon_top pcimon_checker #(.AD_W(AD_W)) u_checker (.*);

// File: tb/pcimon_top_tb_top.sv
`timescale 1ns/1ps
module pcimon_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe_n = '0;
  logic        bus_par = 1'b0;
  logic        bus_frame_n = 1'b1, bus_irdy_n = 1'b1, bus_trdy_n = 1'b1;
  logic        bus_devsel_n = 1'b1, bus_stop_n = 1'b1;

  logic        mon_valid, mon_idle, mon_addr_ph, mon_data_ph, mon_xfer;
  logic        mon_par_valid, mon_par_err, mon_cmd_rsvd, mon_err_nodev, mon_err_spdev;
  logic [3:0]  mon_cmd, mon_be_n;
  logic [1:0]  mon_class;
  logic [31:0] mon_addr, mon_data;

  always #4 clk = ~clk;

  pcimon_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n), .bus_par(bus_par),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .bus_trdy_n(bus_trdy_n),
    .bus_devsel_n(bus_devsel_n), .bus_stop_n(bus_stop_n),
    .mon_valid(mon_valid), .mon_idle(mon_idle), .mon_addr_ph(mon_addr_ph),
    .mon_data_ph(mon_data_ph), .mon_xfer(mon_xfer), .mon_par_valid(mon_par_valid),
    .mon_par_err(mon_par_err), .mon_cmd(mon_cmd), .mon_class(mon_class),
    .mon_cmd_rsvd(mon_cmd_rsvd), .mon_addr(mon_addr), .mon_data(mon_data),
    .mon_be_n(mon_be_n), .mon_err_nodev(mon_err_nodev), .mon_err_spdev(mon_err_spdev)
  );

  typedef struct {
    bit valid, idle, addr, data, xfer, pv, pe, rsvd, nodev, spdev;
    logic [3:0]  cmd, be;
    logic [1:0]  cls;
    logic [31:0] a, d;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state, kept from the requirement text.
  int          m_state = 0;   // 0 none, 1 second address due, 2 data
  bit          m_special = 0, m_due = 0, m_prevpar = 0;
  logic [3:0]  m_cmd = '0, m_be = '0;
  logic [31:0] m_addr = '0, m_data = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit fr, input bit ir, input bit tr, input bit dv, input bit st,
                     input logic [31:0] ad, input logic [3:0] cbe, input bit bad = 0);
    exp_t e;
    logic p;
    @(negedge clk);
    p = m_prevpar ^ bad;
    bus_frame_n = fr; bus_irdy_n = ir; bus_trdy_n = tr; bus_devsel_n = dv; bus_stop_n = st;
    bus_ad = ad; bus_cbe_n = cbe; bus_par = p;
    e.valid = 1; e.idle = fr & ir; e.addr = 0; e.data = 0; e.xfer = 0; e.nodev = 0; e.spdev = 0;
    e.pv = m_due; e.pe = m_due && (p != m_prevpar);
    if (e.idle) m_state = 0;
    else if (m_state == 0) begin
      if (!fr) begin
        e.addr = 1; m_cmd = cbe; m_addr = ad; m_special = (cbe == 4'b0001);
        m_state = (cbe == 4'b1101) ? 1 : 2;
      end
    end else if (m_state == 1) begin
      e.addr = 1; m_cmd = cbe; m_special = (cbe == 4'b0001); m_state = 2;
    end else begin
      e.data = 1; e.xfer = !ir && !tr; m_data = ad; m_be = cbe;
      e.nodev = !m_special && e.xfer && dv;
      e.spdev = m_special && !dv;
      if (fr && !ir && (!tr || !st)) m_state = 0;
    end
    e.cmd = m_cmd; e.a = m_addr; e.d = m_data; e.be = m_be;
    case (m_cmd[3:1])
      3'b001:  e.cls = 2'b01;
      3'b011:  e.cls = 2'b10;
      3'b101:  e.cls = 2'b11;
      default: e.cls = 2'b00;
    endcase
    e.rsvd = (m_cmd == 4'b0100) || (m_cmd == 4'b0101) || (m_cmd == 4'b1000) || (m_cmd == 4'b1001);
    m_due = e.addr || e.xfer;
    m_prevpar = ^{ad, cbe};
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 1, 32'h0, 4'hF);
  endtask

  // Scoreboard monitor: compares each record with the expectation pushed two cycles before.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() >= 2) begin
        exp_t e;
        e = q.pop_front();
        chk("R1",    "valid",   mon_valid,     e.valid);
        chk("R2",    "idle",    mon_idle,      e.idle);
        chk("R3",    "addr_ph", mon_addr_ph,   e.addr);
        chk("R3 R4", "cmd",     mon_cmd,       e.cmd);
        chk("R3 R4", "addr",    mon_addr,      e.a);
        chk("R5 R6", "data_ph", mon_data_ph,   e.data);
        chk("R5",    "xfer",    mon_xfer,      e.xfer);
        chk("R5",    "data",    mon_data,      e.d);
        chk("R5",    "be_n",    mon_be_n,      e.be);
        chk("R7",    "class",   mon_class,     e.cls);
        chk("R7",    "rsvd",    mon_cmd_rsvd,  e.rsvd);
        chk("R8",    "par_vld", mon_par_valid, e.pv);
        chk("R9",    "par_err", mon_par_err,   e.pe);
        chk("R10",   "nodev",   mon_err_nodev, e.nodev);
        chk("R11",   "spdev",   mon_err_spdev, e.spdev);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state of every output
    chk("R12", "reset valid", mon_valid, 0);
    chk("R12", "reset flags", {mon_idle, mon_addr_ph, mon_data_ph, mon_xfer, mon_par_valid,
                               mon_par_err, mon_cmd_rsvd, mon_err_nodev, mon_err_spdev}, 0);
    chk("R12", "reset cmd/class/be", {mon_cmd, mon_class, mon_be_n}, 0);
    chk("R12", "reset addr", mon_addr, 0);
    chk("R12", "reset data", mon_data, 0);
    rst_n = 1'b1;
    idle(2);
    // memory write, single transfer
    cyc(0,1,1,1,1, 32'h1000_0040, 4'b0111);
    cyc(1,0,0,0,1, 32'hCAFE_0001, 4'b0000);
    idle(1);
    // memory read burst with a target wait state, bad PAR on last phase (R9)
    cyc(0,1,1,1,1, 32'h2000_0100, 4'b0110);
    cyc(0,0,1,0,1, 32'h0,         4'b0000);
    cyc(0,0,0,0,1, 32'h1111_2222, 4'b0000);
    cyc(1,0,0,0,1, 32'h3333_4444, 4'b0011, 1);
    idle(1);
    // configuration read with slow DEVSEL#, then configuration write
    cyc(0,1,1,1,1, 32'h0000_0804, 4'b1010);
    cyc(1,0,1,1,1, 32'h0,         4'b0000);
    cyc(1,0,0,0,1, 32'h8086_1234, 4'b0000);
    idle(1);
    cyc(0,1,1,1,1, 32'h0000_0810, 4'b1011);
    cyc(1,0,0,0,1, 32'h0000_00FF, 4'b1110);
    idle(1);
    // special cycle, nobody claims it: no error
    cyc(0,1,1,1,1, 32'h0,         4'b0001);
    cyc(1,0,1,1,1, 32'h0000_0002, 4'b0000);
    cyc(1,0,1,1,1, 32'h0000_0002, 4'b0000);
    idle(1);
    // special cycle with DEVSEL# asserted (R11)
    cyc(0,1,1,1,1, 32'h0,         4'b0001);
    cyc(1,0,1,0,1, 32'h0000_0003, 4'b0000);
    idle(1);
    // transfer completes with DEVSEL# high (R10)
    cyc(0,1,1,1,1, 32'h3000_0000, 4'b0110);
    cyc(1,0,0,1,1, 32'hDEAD_BEEF, 4'b0000);
    idle(1);
    // dual address cycle (R4)
    cyc(0,1,1,1,1, 32'h4000_0000, 4'b1101);
    cyc(0,1,1,1,1, 32'h0000_0001, 4'b0111);
    cyc(1,0,0,0,1, 32'h5555_AAAA, 4'b1111);
    idle(1);
    // I/O read ended by STOP#, then back-to-back reserved command (R6, R7)
    cyc(0,1,1,1,1, 32'h0000_03F8, 4'b0010);
    cyc(1,0,1,0,0, 32'h0,         4'b1110);
    cyc(0,1,1,1,1, 32'h0000_0C00, 4'b0100);
    cyc(1,0,0,0,1, 32'h0000_0077, 4'b0000);
    idle(1);
    // memory read line burst with a master wait state
    cyc(0,1,1,1,1, 32'h6000_0000, 4'b1110);
    cyc(0,0,0,0,1, 32'hA0A0_0000, 4'b0000);
    cyc(0,1,0,0,1, 32'hA0A0_0001, 4'b0000);
    cyc(0,0,0,0,1, 32'hA0A0_0002, 4'b0000);
    cyc(1,0,0,0,1, 32'hA0A0_0003, 4'b0000);
    idle(1);
    // class-other and reserved codes, master abort ended by idle
    cyc(0,1,1,1,1, 32'h7000_0000, 4'b1100);
    cyc(0,0,1,1,1, 32'h0,         4'b0000);
    cyc(1,0,1,1,1, 32'h0,         4'b0000);
    idle(1);
    cyc(0,1,1,1,1, 32'h7100_0000, 4'b1000);
    cyc(1,0,0,0,1, 32'h0000_0009, 4'b0000);
    idle(4);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule